// File: doc/BRIEF.md
# User-Mode FPU Register-Mode Switch

This block holds the floating-point register mode bit (FR) of a small CPU model. User-mode code changes FR through coprocessor control-register moves. Two control-register indices alias the same bit. A move of the hardwired zero register into one index clears FR. A move of zero into the other index sets FR. Reading the first index returns the current mode.

The switch works only when two conditions both hold. The first is the elaboration-time capability parameter, which is reported in the implementation register. The second is the enable bit of a configuration register, written on a privileged path. When the conditions fail, a move to either alias index does not change FR. Instead it raises a one-cycle unpredictable-operation pulse that the exception logic around the block can act on.

Control reads are combinational from the request. FR and the unpredictable pulse are registered.

Top module: `fpu_mode_ctl`

## Requirements
- R1: After reset, `fr_mode` is 0, `cfg_rdata` bit 2 is 0 and `unpred` is 0.
- R2: A read of control index 0 returns `CAP_UFR` in bit 28 and `IMPL_ID` in bits 15:0, with all other bits 0. A write to index 0 changes neither the value read back nor `fr_mode`.
- R3: With `CAP_UFR`=1, `cfg_wr` loads `cfg_en_in` into the enable bit. The enable bit reads back at `cfg_rdata` bit 2 from the next cycle, and all other `cfg_rdata` bits read 0.
- R4: When enabled, a read of control index 1 returns `fr_mode` in bit 0 and 0 in bits 31:1, with no `unpred` pulse.
- R5: When enabled, a zero-source write to index 1 clears `fr_mode` from the next cycle. A zero-source write means `ctl_src_zero`=1 and `ctl_wdata`=0.
- R6: When enabled, a zero-source write to index 4 sets `fr_mode` from the next cycle.
- R7: A write to index 1 or 4 that is not zero-source, or that happens while disabled, leaves `fr_mode` unchanged. It drives `unpred` high for exactly the following cycle. `unpred` is never high in the cycle after a cycle with no request.
- R8: While disabled, a read of index 1 returns 0 and drives `unpred` high for the following cycle.
- R9: With `CAP_UFR`=0, `cfg_rdata` bit 2 stays 0 whatever `cfg_wr` does, and the switch can never be used.
- R10: Reads of indices other than 0 and 1 return 0. Writes to indices other than 1 and 4 have no effect and raise no `unpred`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Move-to-control request |
| ctl_rd | input | 1 | Move-from-control request |
| ctl_idx | input | 5 | Control-register index |
| ctl_wdata | input | 32 | Write data of a move-to-control |
| ctl_src_zero | input | 1 | Write source is the hardwired zero register |
| cfg_wr | input | 1 | Privileged write of the configuration enable bit |
| cfg_en_in | input | 1 | New value of the configuration enable bit |
| cfg_rdata | output | 32 | Configuration register value, enable in bit 2 |
| ctl_rdata | output | 32 | Read data for the current `ctl_rd` request |
| fr_mode | output | 1 | Current FR mode |
| unpred | output | 1 | One-cycle unpredictable-operation pulse |

## Verification
Control read data is due in the same cycle as the request. The bench samples it 1 ns after driving the inputs on the falling edge. `fr_mode`, the enable bit and `unpred` change on the rising edge that accepts the request. The bench checks them at the next falling edge. It then checks `unpred` once more a cycle later to confirm the pulse lasts one cycle. A second instance built without the capability is driven by the same stimulus to cover the disabled-by-design case.

// File: rtl/fpu_mode_ctl.sv
module fpu_mode_ctl #(
  parameter bit          CAP_UFR = 1'b1,
  parameter logic [15:0] IMPL_ID = 16'h0A51
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic        ctl_rd,
  input  logic [4:0]  ctl_idx,
  input  logic [31:0] ctl_wdata,
  input  logic        ctl_src_zero,
  input  logic        cfg_wr,
  input  logic        cfg_en_in,
  output logic [31:0] cfg_rdata,
  output logic [31:0] ctl_rdata,
  output logic        fr_mode,
  output logic        unpred
);
  localparam logic [4:0] IDX_IMPL = 5'd0;
  localparam logic [4:0] IDX_CLR  = 5'd1;
  localparam logic [4:0] IDX_SET  = 5'd4;
  localparam int         CAP_BIT  = 28;
  localparam int         EN_BIT   = 2;

  logic en_q, fr_q, unpred_q;
  logic live, src_ok, alias_hit, good_wr, bad_wr, bad_rd;

  generate
    if (CAP_UFR) begin : g_cap
      always_ff @(posedge clk)
        if (!rst_n)      en_q <= 1'b0;
        else if (cfg_wr) en_q <= cfg_en_in;
    end else begin : g_nocap
      assign en_q = 1'b0;
    end
  endgenerate

  assign live      = en_q;
  assign src_ok    = ctl_src_zero && (ctl_wdata == '0);
  assign alias_hit = (ctl_idx == IDX_CLR) || (ctl_idx == IDX_SET);
  assign good_wr   = ctl_wr && alias_hit && live && src_ok;
  assign bad_wr    = ctl_wr && alias_hit && !(live && src_ok);
  assign bad_rd    = ctl_rd && (ctl_idx == IDX_CLR) && !live;

  always_ff @(posedge clk)
    if (!rst_n) begin
      fr_q     <= 1'b0;
      unpred_q <= 1'b0;
    end else begin
      if (good_wr) fr_q <= (ctl_idx == IDX_SET);
      unpred_q <= bad_wr || bad_rd;
    end

  always_comb begin
    ctl_rdata = '0;
    if (ctl_rd) begin
      if (ctl_idx == IDX_IMPL) begin
        ctl_rdata[15:0]    = IMPL_ID;
        ctl_rdata[CAP_BIT] = CAP_UFR;
      end else if (ctl_idx == IDX_CLR && live) begin
        ctl_rdata[0] = fr_q;
      end
    end
  end

  always_comb begin
    cfg_rdata         = '0;
    cfg_rdata[EN_BIT] = en_q;
  end

  assign fr_mode = fr_q;
  assign unpred  = unpred_q;
endmodule

module fpu_mode_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_wr,
  input logic        ctl_rd,
  input logic [4:0]  ctl_idx,
  input logic [31:0] ctl_wdata,
  input logic        ctl_src_zero,
  input logic [31:0] cfg_rdata,
  input logic [31:0] ctl_rdata,
  input logic        fr_mode,
  input logic        unpred
);
  logic zmove, on, alias_w;
  assign zmove   = ctl_src_zero && (ctl_wdata == 32'd0);
  assign on      = cfg_rdata[2];
  assign alias_w = ctl_wr && (ctl_idx == 5'd1 || ctl_idx == 5'd4);

  AST_FR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_idx == 5'd1 && zmove && on) |=> !fr_mode); // R5
  AST_FR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_idx == 5'd4 && zmove && on) |=> fr_mode); // R6
  AST_FR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(alias_w && zmove && on) |=> $stable(fr_mode)); // R7
  AST_BAD_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (alias_w && !(zmove && on)) |=> unpred); // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_wr || ctl_rd) |=> !unpred); // R7
  AST_RD_FR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd && ctl_idx == 5'd1 && on) |-> ctl_rdata == {31'd0, fr_mode}); // R4
  AST_RD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd && ctl_idx == 5'd1 && !on) |-> ctl_rdata == 32'd0); // R8
  AST_CFG_ONLY_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~32'h4) == 32'd0); // R3
endmodule

bind fpu_mode_ctl fpu_mode_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
  .ctl_idx(ctl_idx), .ctl_wdata(ctl_wdata), .ctl_src_zero(ctl_src_zero),
  .cfg_rdata(cfg_rdata), .ctl_rdata(ctl_rdata), .fr_mode(fr_mode),
  .unpred(unpred)
);

// File: tb/fpu_mode_ctl_tb.sv
module fpu_mode_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0, ctl_rd = 1'b0, ctl_src_zero = 1'b0;
  logic [4:0]  ctl_idx = '0;
  logic [31:0] ctl_wdata = '0;
  logic        cfg_wr = 1'b0, cfg_en_in = 1'b0;
  logic [31:0] cfg_rdata, ctl_rdata, n_cfg_rdata, n_ctl_rdata;
  logic        fr_mode, unpred, n_fr_mode, n_unpred;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] rd_now, n_rd_now;

  always #5 clk = ~clk;

  fpu_mode_ctl #(.CAP_UFR(1'b1), .IMPL_ID(16'h0A51)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
    .ctl_idx(ctl_idx), .ctl_wdata(ctl_wdata), .ctl_src_zero(ctl_src_zero),
    .cfg_wr(cfg_wr), .cfg_en_in(cfg_en_in), .cfg_rdata(cfg_rdata),
    .ctl_rdata(ctl_rdata), .fr_mode(fr_mode), .unpred(unpred));

  fpu_mode_ctl #(.CAP_UFR(1'b0), .IMPL_ID(16'h0A51)) u_nocap (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
    .ctl_idx(ctl_idx), .ctl_wdata(ctl_wdata), .ctl_src_zero(ctl_src_zero),
    .cfg_wr(cfg_wr), .cfg_en_in(cfg_en_in), .cfg_rdata(n_cfg_rdata),
    .ctl_rdata(n_ctl_rdata), .fr_mode(n_fr_mode), .unpred(n_unpred));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input logic wr, input logic rd, input logic [4:0] idx,
                    input logic [31:0] wd, input logic z);
    @(negedge clk);
    ctl_wr = wr; ctl_rd = rd; ctl_idx = idx; ctl_wdata = wd; ctl_src_zero = z;
    #1 rd_now = ctl_rdata; n_rd_now = n_ctl_rdata;
    @(negedge clk);
    ctl_wr = 0; ctl_rd = 0; ctl_idx = 0; ctl_wdata = 0; ctl_src_zero = 0;
  endtask

  task automatic cfg(input logic v);
    @(negedge clk);
    cfg_wr = 1; cfg_en_in = v;
    @(negedge clk);
    cfg_wr = 0; cfg_en_in = 0;
  endtask

  task automatic t_reset;
    chk("R1 fr", {31'd0, fr_mode}, 0);
    chk("R1 cfg", cfg_rdata, 0);
    chk("R1 unpred", {31'd0, unpred}, 0);
  endtask

  task automatic t_impl;
    op(0, 1, 5'd0, 0, 0);
    chk("R2 impl", rd_now, 32'h1000_0A51);
    chk("R9 impl nocap", n_rd_now, 32'h0000_0A51);
    op(1, 0, 5'd0, 32'hFFFF_FFFF, 0);
    chk("R2 wr unpred", {31'd0, unpred}, 0);
    op(0, 1, 5'd0, 0, 0);
    chk("R2 impl after wr", rd_now, 32'h1000_0A51);
  endtask

  task automatic t_disabled;
    op(1, 0, 5'd4, 0, 1);
    chk("R7 disabled fr", {31'd0, fr_mode}, 0);
    chk("R7 disabled unpred", {31'd0, unpred}, 1);
    @(negedge clk);
    chk("R7 one cycle", {31'd0, unpred}, 0);
    op(0, 1, 5'd1, 0, 0);
    chk("R8 rd off", rd_now, 0);
    chk("R8 unpred", {31'd0, unpred}, 1);
  endtask

  task automatic t_cfg;
    cfg(1);
    chk("R3 en", cfg_rdata, 32'h4);
    chk("R9 nocap cfg", n_cfg_rdata, 0);
    cfg(0);
    chk("R3 dis", cfg_rdata, 0);
    cfg(1);
  endtask

  task automatic t_switch;
    op(1, 0, 5'd4, 0, 1);
    chk("R6 set", {31'd0, fr_mode}, 1);
    chk("R6 no unpred", {31'd0, unpred}, 0);
    chk("R9 nocap fr", {31'd0, n_fr_mode}, 0);
    chk("R9 nocap unpred", {31'd0, n_unpred}, 1);
    op(0, 1, 5'd1, 0, 0);
    chk("R4 rd one", rd_now, 1);
    chk("R4 no unpred", {31'd0, unpred}, 0);
    op(1, 0, 5'd1, 0, 1);
    chk("R5 clear", {31'd0, fr_mode}, 0);
    op(0, 1, 5'd1, 0, 0);
    chk("R4 rd zero", rd_now, 0);
    op(1, 0, 5'd4, 0, 1);
    chk("R6 set again", {31'd0, fr_mode}, 1);
  endtask

  task automatic t_bad;
    op(1, 0, 5'd1, 32'h5, 0);
    chk("R7 nonzero fr", {31'd0, fr_mode}, 1);
    chk("R7 nonzero unpred", {31'd0, unpred}, 1);
    op(1, 0, 5'd1, 32'h5, 1);
    chk("R7 flag data fr", {31'd0, fr_mode}, 1);
    chk("R7 flag data unpred", {31'd0, unpred}, 1);
    op(1, 0, 5'd2, 0, 1);
    chk("R10 other wr fr", {31'd0, fr_mode}, 1);
    chk("R10 other wr unpred", {31'd0, unpred}, 0);
    op(0, 1, 5'd4, 0, 0);
    chk("R10 rd idx4", rd_now, 0);
    chk("R10 rd idx4 unpred", {31'd0, unpred}, 0);
    cfg(0);
    op(1, 0, 5'd1, 0, 1);
    chk("R7 disabled clear fr", {31'd0, fr_mode}, 1);
    chk("R7 disabled clear unpred", {31'd0, unpred}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_impl();
    t_disabled();
    t_cfg();
    t_switch();
    t_bad();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule